// File: doc/BRIEF.md
# Block-Mode FIFO Service Request Logic

This block sits between the software side and the serial shifter of a byte-oriented serial controller. It holds one transmit FIFO and one receive FIFO and turns their fill levels into service requests sized in blocks of four bytes. Software programs how many bytes a run sends and how many it receives, then raises `run`. The block asks for output when the transmit FIFO has room for the next block and bytes are still owed. It asks for input when the receive FIFO holds the next block. The last block of a run may be shorter than four bytes. Each request is one flag that software clears by writing a one to its bit. The block also reports FIFO levels, flags completion of each programmed count and records overrun and underrun errors in sticky bits.

Dropping `run` flushes both FIFOs and clears every counter and request flag. The error bits are left as they are. The programmed counts must be held steady while `run` is high. The shifter pops transmit bytes with `tx_pop` and pushes received bytes with `rx_push`. Software writes transmit bytes with `sw_wr` and reads received bytes with `sw_rd`.

Top module: `blk_fifo_svc`

## Requirements
- R1: After reset, and whenever `run` is low, `op_status` reads zero. After reset `err_status` also reads zero.
- R2: While running with output enabled and bytes still owed (`out_max` minus bytes accepted), bit 8 of `op_status` sets once the transmit FIFO has free space for at least min(4, owed) bytes. That grant may be a final partial block.
- R3: A write on `op_wdata` with bit 8 (or bit 9) at one clears the output (or input) service flag. Zero bits have no effect.
- R4: After a request is raised, the same flag is not raised again until software has moved the whole granted block through its side of the FIFO.
- R5: While running with input enabled, bit 9 sets once the receive FIFO holds at least min(4, bytes still to be read) bytes. This includes a final block shorter than four.
- R6: Bit 10 reads one when the bytes popped by the shifter equal `out_max`. Bit 11 reads one when the bytes received equal `in_max`.
- R7: FIFO status bits: 7 is receive FIFO full, 6 is transmit FIFO full, 5 is receive not empty and 4 is transmit not empty.
- R8: A software write to a full transmit FIFO, while bytes are still owed, sets error bit 5 (output overrun) and drops the byte.
- R9: A software read of an empty receive FIFO returns zero and sets error bit 4 (input underrun).
- R10: A shifter pop of an empty transmit FIFO, while fewer than `out_max` bytes have been sent, sets error bit 3 (output underrun). Once the count is reached, such a pop leaves bit 3 alone.
- R11: A shifter push into a full receive FIFO, while the receive count is not yet reached, sets error bit 2 (input overrun) and drops the byte.
- R12: Error bits stay set until a write on `err_wdata` puts a one in their position. A clear touches only the bits written as one.
- R13: With `out_off` high, software writes are ignored and no output request is raised. With `in_off` high, shifter pushes are ignored.
- R14: Both FIFOs keep byte order. Software writes after `out_max` bytes have been accepted, and shifter pushes after `in_max` bytes have been received, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Run state; low flushes FIFOs, counters and requests |
| in_off | input | 1 | Disables the receive path |
| out_off | input | 1 | Disables the transmit path |
| out_max | input | 16 | Bytes to send in this run |
| in_max | input | 16 | Bytes to receive in this run |
| sw_wr | input | 1 | Software write strobe into the transmit FIFO |
| sw_wdata | input | 8 | Software write byte |
| sw_rd | input | 1 | Software read strobe from the receive FIFO |
| sw_rdata | output | 8 | Receive FIFO head, zero when empty |
| op_wr | input | 1 | Write strobe for the request-acknowledge word |
| op_wdata | input | 16 | Acknowledge word; ones at bits 8 and 9 clear requests |
| err_wr | input | 1 | Write strobe for the error-clear word |
| err_wdata | input | 6 | Error-clear word; ones clear bits |
| tx_pop | input | 1 | Shifter takes a transmit byte |
| tx_data | output | 8 | Transmit FIFO head |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_data | input | 8 | Received byte |
| op_status | output | 16 | Requests, done flags and FIFO status |
| err_status | output | 6 | Sticky error flags |

## Verification
The bench goes after the short final block. A design that always waited for four bytes would hang at the end of any run whose count is not a multiple of four. It presses on the one-block grant: a design that re-raised a request while a granted block was still being written would let software overfill the FIFO. The bench also checks the two sides of each count limit. A full-FIFO write must set overrun and drop the byte, which shows up as wrong data order. A write past the count must be silently ignored, which shows up as a stale byte left in the FIFO. An empty pop after the count is reached must not be reported as underrun. Error clears are checked bit by bit, because a design that cleared the whole word would lose an unrelated pending error.

// File: rtl/blk_fifo_svc_pkg.sv
package blk_fifo_svc_pkg;

    localparam int BLK_BYTES = 4;
    localparam int CNT_W     = 16;
    localparam int DW        = 8;

    typedef enum int unsigned {
        OPB_OUT_NE   = 4,
        OPB_IN_NE    = 5,
        OPB_OUT_FULL = 6,
        OPB_IN_FULL  = 7,
        OPB_OUT_SVC  = 8,
        OPB_IN_SVC   = 9,
        OPB_OUT_DONE = 10,
        OPB_IN_DONE  = 11
    } op_bit_e;

    typedef enum int unsigned {
        ERB_IN_OVER   = 2,
        ERB_OUT_UNDER = 3,
        ERB_IN_UNDER  = 4,
        ERB_OUT_OVER  = 5
    } err_bit_e;

    typedef struct packed {
        logic in_done;
        logic out_done;
        logic in_svc;
        logic out_svc;
        logic in_full;
        logic out_full;
        logic in_ne;
        logic out_ne;
    } op_flags_t;

    function automatic logic [15:0] pack_status(input op_flags_t f);
        logic [15:0] w;
        w = '0;
        w[OPB_OUT_NE]   = f.out_ne;
        w[OPB_IN_NE]    = f.in_ne;
        w[OPB_OUT_FULL] = f.out_full;
        w[OPB_IN_FULL]  = f.in_full;
        w[OPB_OUT_SVC]  = f.out_svc;
        w[OPB_IN_SVC]   = f.in_svc;
        w[OPB_OUT_DONE] = f.out_done;
        w[OPB_IN_DONE]  = f.in_done;
        return w;
    endfunction

endpackage

// File: rtl/svc_byte_fifo.sv
module svc_byte_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assert_no_push_full_R8: assert property (@(posedge clk) disable iff (rst)
        !(push && full));
    assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (rst)
        !(pop && empty));

endmodule

// File: rtl/svc_req_ctrl.sv
module svc_req_ctrl #(
    parameter int BLK   = 4,
    parameter int CNT_W = 16,
    parameter int AVW   = 4,
    localparam int CRW  = $clog2(BLK + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             enable,
    input  logic [AVW-1:0]   avail,
    input  logic [CNT_W-1:0] remaining,
    input  logic             consume,
    input  logic             ack,
    output logic             svc,
    output logic [CRW-1:0]   credit
);

    logic [CNT_W-1:0] grant;
    logic             raise;

    assign grant = (remaining < CNT_W'(BLK)) ? remaining : CNT_W'(BLK);
    assign raise = enable && !svc && (credit == '0) && (remaining != '0)
                   && (CNT_W'(avail) >= grant);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            svc    <= 1'b0;
            credit <= '0;
        end else if (raise) begin
            svc    <= 1'b1;
            credit <= CRW'(grant);
        end else begin
            if (ack) svc <= 1'b0;
            if (consume && credit != '0) credit <= credit - 1'b1;
        end
    end

    assert_credit_within_owed_R4: assert property (@(posedge clk) disable iff (rst)
        CNT_W'(credit) <= remaining);
    assert_raise_loads_credit_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(svc) |-> (credit != '0) && ($past(credit) == '0));

endmodule

// File: rtl/blk_fifo_svc.sv
module blk_fifo_svc
    import blk_fifo_svc_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic        in_off,
    input  logic        out_off,
    input  logic [15:0] out_max,
    input  logic [15:0] in_max,
    input  logic        sw_wr,
    input  logic [7:0]  sw_wdata,
    input  logic        sw_rd,
    output logic [7:0]  sw_rdata,
    input  logic        op_wr,
    input  logic [15:0] op_wdata,
    input  logic        err_wr,
    input  logic [5:0]  err_wdata,
    input  logic        tx_pop,
    output logic [7:0]  tx_data,
    input  logic        rx_push,
    input  logic [7:0]  rx_data,
    output logic [15:0] op_status,
    output logic [5:0]  err_status
);

    localparam int CW = $clog2(DEPTH + 1);

    logic clr, out_en, in_en;
    logic [CNT_W-1:0] out_acc, out_sent, in_rcvd, in_taken;
    logic [CNT_W-1:0] out_owed, in_left;
    logic [CW-1:0] out_cnt, in_cnt, out_free;
    logic out_full, out_empty, in_full, in_empty;
    logic [DW-1:0] in_head;
    logic wr_try, out_push, out_pop, rx_try, in_push, in_pop;
    logic out_svc, in_svc;
    logic [5:0] err_q, err_set, err_clr;
    op_flags_t flags;
    logic unused_ok;

    assign clr    = !run;
    assign out_en = run && !out_off;
    assign in_en  = run && !in_off;

    assign out_owed = out_max - out_acc;
    assign in_left  = in_max - in_taken;
    assign out_free = CW'(DEPTH) - out_cnt;

    assign wr_try   = sw_wr && out_en && (out_owed != '0);
    assign out_push = wr_try && !out_full;
    assign out_pop  = tx_pop && !out_empty;
    assign rx_try   = rx_push && in_en && (in_rcvd != in_max);
    assign in_push  = rx_try && !in_full;
    assign in_pop   = sw_rd && !in_empty;

    assign sw_rdata = in_empty ? '0 : in_head;

    svc_byte_fifo #(.DEPTH(DEPTH), .W(DW)) u_tx_fifo (
        .clk(clk), .rst(rst), .clear(clr),
        .push(out_push), .din(sw_wdata), .pop(out_pop),
        .head(tx_data), .count(out_cnt), .full(out_full), .empty(out_empty)
    );

    svc_byte_fifo #(.DEPTH(DEPTH), .W(DW)) u_rx_fifo (
        .clk(clk), .rst(rst), .clear(clr),
        .push(in_push), .din(rx_data), .pop(in_pop),
        .head(in_head), .count(in_cnt), .full(in_full), .empty(in_empty)
    );

    svc_req_ctrl #(.BLK(BLK_BYTES), .CNT_W(CNT_W), .AVW(CW)) u_out_req (
        .clk(clk), .rst(rst), .clear(clr), .enable(out_en),
        .avail(out_free), .remaining(out_owed), .consume(out_push),
        .ack(op_wr && op_wdata[OPB_OUT_SVC]), .svc(out_svc), .credit()
    );

    svc_req_ctrl #(.BLK(BLK_BYTES), .CNT_W(CNT_W), .AVW(CW)) u_in_req (
        .clk(clk), .rst(rst), .clear(clr), .enable(in_en),
        .avail(in_cnt), .remaining(in_left), .consume(in_pop),
        .ack(op_wr && op_wdata[OPB_IN_SVC]), .svc(in_svc), .credit()
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            out_acc  <= '0;
            out_sent <= '0;
            in_rcvd  <= '0;
            in_taken <= '0;
        end else begin
            if (out_push) out_acc  <= out_acc + 1'b1;
            if (out_pop)  out_sent <= out_sent + 1'b1;
            if (in_push)  in_rcvd  <= in_rcvd + 1'b1;
            if (in_pop)   in_taken <= in_taken + 1'b1;
        end
    end

    always_comb begin
        err_set                = '0;
        err_set[ERB_OUT_OVER]  = wr_try && out_full;
        err_set[ERB_IN_UNDER]  = sw_rd && run && in_empty;
        err_set[ERB_OUT_UNDER] = tx_pop && out_empty && out_en && (out_sent != out_max);
        err_set[ERB_IN_OVER]   = rx_try && in_full;
        err_clr                = err_wr ? err_wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= '0;
        else     err_q <= ((err_q & ~err_clr) | err_set) & 6'b111100;
    end

    always_comb begin
        flags.out_ne   = !out_empty;
        flags.in_ne    = !in_empty;
        flags.out_full = out_full;
        flags.in_full  = in_full;
        flags.out_svc  = out_svc;
        flags.in_svc   = in_svc;
        flags.out_done = out_en && (out_sent == out_max);
        flags.in_done  = in_en && (in_rcvd == in_max);
    end

    assign op_status  = pack_status(flags);
    assign err_status = err_q;
    assign unused_ok  = ^{op_wdata[15:10], op_wdata[7:0]};

    assert_overrun_drops_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_try && out_full && !tx_pop && run) |=> (out_cnt == $past(out_cnt)));
    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (err_q[ERB_OUT_OVER] && !(err_wr && err_wdata[ERB_OUT_OVER])) |=> err_q[ERB_OUT_OVER]);
    assert_sent_le_accepted_R6: assert property (@(posedge clk) disable iff (rst)
        out_sent <= out_acc);

endmodule

// File: tb/blk_fifo_svc_tb.sv
module blk_fifo_svc_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, run, in_off, out_off;
    logic [15:0] out_max, in_max;
    logic        sw_wr, sw_rd, op_wr, err_wr, tx_pop, rx_push;
    logic [7:0]  sw_wdata, sw_rdata, tx_data, rx_data;
    logic [15:0] op_wdata, op_status;
    logic [5:0]  err_wdata, err_status;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    blk_fifo_svc u_dut (
        .clk(clk), .rst(rst), .run(run), .in_off(in_off), .out_off(out_off),
        .out_max(out_max), .in_max(in_max),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rd(sw_rd), .sw_rdata(sw_rdata),
        .op_wr(op_wr), .op_wdata(op_wdata), .err_wr(err_wr), .err_wdata(err_wdata),
        .tx_pop(tx_pop), .tx_data(tx_data), .rx_push(rx_push), .rx_data(rx_data),
        .op_status(op_status), .err_status(err_status)
    );

    function automatic int exp_grant(input int left);
        return (left < 4) ? left : 4;
    endfunction

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic [7:0] b);
        sw_wr = 1'b1; sw_wdata = b; cyc(); sw_wr = 1'b0;
    endtask

    task automatic rx_in(input logic [7:0] b);
        rx_push = 1'b1; rx_data = b; cyc(); rx_push = 1'b0;
    endtask

    task automatic ack(input logic [15:0] w);
        op_wr = 1'b1; op_wdata = w; cyc(); op_wr = 1'b0;
    endtask

    task automatic err_clear(input logic [5:0] w);
        err_wr = 1'b1; err_wdata = w; cyc(); err_wr = 1'b0;
    endtask

    task automatic pop_tx_check(input string req);
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(req, tx_data, e);
        tx_pop = 1'b1; cyc(); tx_pop = 1'b0;
    endtask

    task automatic read_check(input string req);
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(req, sw_rdata, e);
        sw_rd = 1'b1; cyc(); sw_rd = 1'b0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] b;
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; run = 1'b0; in_off = 1'b0; out_off = 1'b0;
        out_max = '0; in_max = '0;
        sw_wr = 0; sw_rd = 0; op_wr = 0; err_wr = 0; tx_pop = 0; rx_push = 0;
        sw_wdata = '0; rx_data = '0; op_wdata = '0; err_wdata = '0;
        cyc(3); rst = 1'b0; cyc();
        chk("R1 status after reset", op_status, 16'h0);
        chk("R1 errors after reset", err_status, 6'h0);

        // Output path, count 10
        out_max = 16'd10; in_max = 16'd0; in_off = 1'b1; run = 1'b1; cyc();
        chk("R2 first output request", op_status[8], 1'b1);
        chk("R6 output not done", op_status[10], 1'b0);
        ack(16'h0000);
        chk("R3 zero write keeps flag", op_status[8], 1'b1);
        ack(16'h0100);
        chk("R3 write-one clears flag", op_status[8], 1'b0);
        cyc(3);
        chk("R4 no re-raise while grant open", op_status[8], 1'b0);
        for (int i = 0; i < 4; i++) begin
            b = 8'($urandom); exp_q.push_back(b); sw_write(b);
        end
        cyc();
        chk("R2 second block request", op_status[8], 1'b1);
        chk("R7 tx not empty", op_status[4], 1'b1);
        chk("R7 tx not full", op_status[6], 1'b0);
        ack(16'h0100);
        for (int i = 0; i < 4; i++) begin
            b = 8'($urandom); exp_q.push_back(b); sw_write(b);
        end
        cyc();
        chk("R2 no request without room", op_status[8], 1'b0);
        chk("R7 tx full", op_status[6], 1'b1);
        sw_write(8'hEE);
        chk("R8 output overrun", err_status[5], 1'b1);
        for (int i = 0; i < 8; i++) pop_tx_check("R8 R14 tx order, dropped byte absent");
        chk("R2 partial block request", op_status[8], 1'b1);
        chk("R7 tx empty", op_status[4], 1'b0);
        tx_pop = 1'b1; cyc(); tx_pop = 1'b0;
        chk("R10 output underrun", err_status[3], 1'b1);
        cyc(4);
        chk("R12 overrun still set", err_status[5], 1'b1);
        err_clear(6'h20);
        chk("R12 cleared bit", err_status[5], 1'b0);
        chk("R12 other bit kept", err_status[3], 1'b1);
        err_clear(6'h08);
        ack(16'h0100);
        for (int i = 0; i < 2; i++) begin
            b = 8'($urandom); exp_q.push_back(b); sw_write(b);
        end
        sw_write(8'h5A);
        pop_tx_check("R14 tail byte 1");
        pop_tx_check("R14 tail byte 2");
        chk("R14 write beyond count ignored", op_status[4], 1'b0);
        chk("R6 output done", op_status[10], 1'b1);
        tx_pop = 1'b1; cyc(); tx_pop = 1'b0;
        chk("R10 no underrun after count", err_status[3], 1'b0);
        run = 1'b0; cyc();
        chk("R1 status when not running", op_status, 16'h0);

        // Input path, count 6, output disabled
        in_max = 16'd6; in_off = 1'b0; out_off = 1'b1; out_max = 16'd4; run = 1'b1; cyc();
        sw_write(8'h11);
        chk("R13 disabled output ignores writes", op_status[4], 1'b0);
        chk("R13 disabled output no request", op_status[8], 1'b0);
        for (int i = 0; i < 3; i++) begin
            b = 8'($urandom); exp_q.push_back(b); rx_in(b);
        end
        cyc();
        chk("R5 no request below block", op_status[9], 1'b0);
        b = 8'($urandom); exp_q.push_back(b); rx_in(b);
        cyc();
        chk("R5 full block request", op_status[9], 1'b1);
        chk("R7 rx not empty", op_status[5], 1'b1);
        ack(16'h0200);
        chk("R3 input flag cleared", op_status[9], 1'b0);
        for (int i = 0; i < 4; i++) read_check("R14 rx order");
        for (int i = 0; i < 2; i++) begin
            b = 8'($urandom); exp_q.push_back(b); rx_in(b);
        end
        cyc();
        chk("R5 partial block request", op_status[9], 1'b1);
        chk("R6 input done", op_status[11], 1'b1);
        rx_in(8'hC3);
        read_check("R14 rx tail 1");
        read_check("R14 rx tail 2");
        chk("R14 push beyond count ignored", op_status[5], 1'b0);
        chk("R9 empty read returns zero", sw_rdata, 8'h00);
        sw_rd = 1'b1; cyc(); sw_rd = 1'b0;
        chk("R9 input underrun", err_status[4], 1'b1);
        run = 1'b0; cyc();
        in_max = 16'd20; in_off = 1'b1; run = 1'b1; cyc();
        rx_in(8'h77);
        chk("R13 disabled input ignores pushes", op_status[5], 1'b0);
        run = 1'b0; cyc();

        // Input overrun
        in_off = 1'b0; run = 1'b1; cyc();
        for (int i = 0; i < 9; i++) begin
            b = 8'($urandom); if (i < 8) exp_q.push_back(b); rx_in(b);
        end
        chk("R7 rx full", op_status[7], 1'b1);
        chk("R11 input overrun", err_status[2], 1'b1);
        for (int i = 0; i < 8; i++) read_check("R11 R14 rx order after drop");
        run = 1'b0; err_clear(6'h3F); cyc();

        // Random output runs
        for (int it = 0; it < 6; it++) begin
            int total, written;
            total = 1 + int'($urandom % 12);
            written = 0;
            out_max = 16'(total); out_off = 1'b0; in_off = 1'b1; run = 1'b1; cyc();
            while (written < total) begin
                for (int w = 0; w < 10 && !op_status[8]; w++) cyc();
                chk("R2 random request", op_status[8], 1'b1);
                ack(16'h0100);
                for (int k = 0; k < exp_grant(total - written); k++) begin
                    b = 8'($urandom); exp_q.push_back(b); sw_write(b);
                end
                written += exp_grant(total - written);
                while (exp_q.size() > 0) pop_tx_check("R14 random order");
            end
            chk("R6 random done", op_status[10], 1'b1);
            chk("R12 random no errors", err_status, 6'h0);
            run = 1'b0; cyc();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule